// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block collects eight interrupt conditions of a serial port and reports the most urgent enabled one. The report is an 8-bit identification byte that a host reads. Bit 0 of the byte is an active-low "pending" flag. Bits 5:1 carry a 5-bit code for the source that was chosen. Bits 7:6 repeat the FIFO-enable control bit.

Three sources are level type and follow their input flags: line-status error, receive time-out and receive data ready. The other five are edge type. Each is set by a one-cycle event pulse and stays set until it is cleared. Four of them (modem change, GPIO pin change, Xoff/special character, CTS/RTS deassertion) are cleared by their own clear pulse, which comes from the register that holds their detailed status. The transmit-holding-empty source is cleared by reading the identification byte while that source is the one identified.

Every source is gated by its own enable bit before the priority choice. The identification byte is registered and follows the live choice one cycle later. While the read strobe is high the byte is frozen, so a host read sees a stable value.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled source active, the identification byte reads 0x01 with bits 7:6 set to the FIFO-enable value; bit 0 is 0 only when a source is identified. Out of reset the byte is 0x01.
- R2: Bits 7:6 both equal the FIFO-enable input, sampled at the same edge as the rest of the byte.
- R3: An active line-status error (source index 0) is always chosen and gives code 00011 (byte 0x06 with FIFO disabled).
- R4: Receive time-out (index 1, code 00110, byte 0x0C) is chosen over receive data ready (index 2, code 00010, byte 0x04) when both are active.
- R5: Transmit-holding-empty (index 3) gives code 00001 (byte 0x02). Modem change (index 4) gives code 00000 with bit 0 low (byte 0x00).
- R6: GPIO change (index 5) gives code 11000 (0x30). Xoff/special character (index 6) gives code 01000 (0x10). CTS/RTS deassertion (index 7) gives code 10000 (0x20).
- R7: When several enabled sources are active, the one with the lowest index is identified.
- R8: Enable bit i of the enable vector gates source i. Clearing an enable bit removes that source from the choice at the next update and does not erase its latched event, so setting the bit again brings the source back.
- R9: An edge-type source is set by a one-cycle event pulse and stays set until its clear pulse. An event in the same cycle as a clear leaves it set.
- R10: Level-type sources follow their input flags and have no memory of their own.
- R11: The byte is registered one clock after the live choice and holds its value on every clock edge at which the read strobe is high.
- R12: On the first cycle of a read, if the held byte identifies transmit-holding-empty, that source is cleared. It is set again only by a new event. A read that identifies another source leaves it set.
- R13: The interrupt request output is high exactly when bit 0 of the byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | FIFO-enable control bit, mirrored into bits 7:6 |
| srcEnable | input | 8 | Per-source enable, bit i gates source index i |
| lineErr | input | 1 | Line-status error level (index 0) |
| rxTimeout | input | 1 | Receive time-out level (index 1) |
| rxReady | input | 1 | Receive data ready level (index 2) |
| txEmptyEvt | input | 1 | Transmit-holding-empty event pulse (index 3) |
| modemEvt | input | 1 | Modem change event pulse (index 4) |
| gpioEvt | input | 1 | GPIO pin change event pulse (index 5) |
| xoffEvt | input | 1 | Xoff/special character event pulse (index 6) |
| flowEvt | input | 1 | CTS/RTS deassertion event pulse (index 7) |
| modemClr | input | 1 | Clear pulse for modem source |
| gpioClr | input | 1 | Clear pulse for GPIO source |
| xoffClr | input | 1 | Clear pulse for Xoff source |
| flowClr | input | 1 | Clear pulse for CTS/RTS source |
| idRead | input | 1 | Read strobe for the identification byte |
| idReg | output | 8 | Identification byte |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench targets the two pairs that share or sit close in priority: time-out over data ready, and modem over GPIO. A design with the order swapped would report the lower-priority code. The read side-effect is tested both ways. A design that cleared transmit-empty on any read would lose that source after a read that identified a line error. A design that never cleared it would report 0x02 again after the read. Disabling and then enabling a latched source checks that masking does not erase the latch. A read held high while a line error appears checks that the byte stays frozen and does not slip to the new code.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_SRC  = 8;
  localparam int NUM_LVL  = 3;
  localparam int NUM_EDGE = NUM_SRC - NUM_LVL - 1;
  localparam int CODE_W   = 5;
  localparam int ID_W     = CODE_W + 3;

  typedef enum logic [2:0] {
    SRC_LINE  = 3'd0,
    SRC_TOUT  = 3'd1,
    SRC_RXRDY = 3'd2,
    SRC_THR   = 3'd3,
    SRC_MODEM = 3'd4,
    SRC_GPIO  = 3'd5,
    SRC_XOFF  = 3'd6,
    SRC_FLOW  = 3'd7
  } srcIdxT;

  typedef struct packed {
    logic holdId;
    logic thrClr;
  } ctrlStrobeT;

  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      0:       c = 5'b00011;
      1:       c = 5'b00110;
      2:       c = 5'b00010;
      3:       c = 5'b00001;
      4:       c = 5'b00000;
      5:       c = 5'b11000;
      6:       c = 5'b01000;
      7:       c = 5'b10000;
      default: c = 5'b00000;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LVL-1:0]  lvlSrc,
  input  logic                txEmptyEvt,
  input  logic [NUM_EDGE-1:0] edgeEvt,
  input  logic [NUM_EDGE-1:0] edgeClr,
  input  logic                idRead,
  input  logic                thrIdentified,
  output logic [NUM_SRC-1:0]  pend,
  output ctrlStrobeT          strobe
);
  logic                idReadQ;
  logic                thrLatch;
  logic [NUM_EDGE-1:0] edgeLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idReadQ <= 1'b0;
    else       idReadQ <= idRead;
  end

  always_comb begin
    strobe.holdId = idRead;
    strobe.thrClr = idRead && !idReadQ && thrIdentified;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thrLatch <= 1'b0;
    else       thrLatch <= txEmptyEvt | (thrLatch & ~strobe.thrClr);
  end

  for (genvar g = 0; g < NUM_EDGE; g++) begin : gEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) edgeLatch[g] <= 1'b0;
      else       edgeLatch[g] <= edgeEvt[g] | (edgeLatch[g] & ~edgeClr[g]);
    end
  end

  assign pend = {edgeLatch, thrLatch, lvlSrc};

  a_r12_thr_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.thrClr && !txEmptyEvt) |=> !pend[SRC_THR]);
  a_r9_edge_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pend[SRC_MODEM] && !edgeClr[0]) |=> pend[SRC_MODEM]);
  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    edgeEvt[1] |=> pend[SRC_GPIO]);
endmodule

// File: rtl/uirq_dp.sv
module uirq_dp
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  ctrlStrobeT         strobe,
  output logic [ID_W-1:0]    idReg,
  output logic               thrIdentified
);
  localparam logic [ID_W-1:0] ID_IDLE = 8'h01;

  logic [NUM_SRC-1:0] active;
  logic               found;
  int                 sel;
  logic [ID_W-1:0]    liveId;

  assign active = pend & srcEnable;

  always_comb begin
    sel = 0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) sel = i;
    end
    found  = |active;
    liveId = {fifoEn, fifoEn, (found ? srcCode(sel) : {CODE_W{1'b0}}), ~found};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idReg <= ID_IDLE;
    else if (!strobe.holdId) idReg <= liveId;
  end

  assign thrIdentified = (idReg[CODE_W:0] == {srcCode(SRC_THR), 1'b0});

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdId |=> $stable(idReg));
  a_r1_idle_value: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.holdId && !(|active)) |=> idReg[CODE_W:0] == 6'b000001);
  a_r3_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.holdId && active[SRC_LINE]) |=> idReg[CODE_W:0] == 6'b000110);
  a_r2_mirror: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.holdId |=> idReg[ID_W-1:ID_W-2] == {2{$past(fifoEn)}});
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic [7:0] srcEnable,
  input  logic       lineErr,
  input  logic       rxTimeout,
  input  logic       rxReady,
  input  logic       txEmptyEvt,
  input  logic       modemEvt,
  input  logic       gpioEvt,
  input  logic       xoffEvt,
  input  logic       flowEvt,
  input  logic       modemClr,
  input  logic       gpioClr,
  input  logic       xoffClr,
  input  logic       flowClr,
  input  logic       idRead,
  output logic [7:0] idReg,
  output logic       irqOut
);
  logic [NUM_SRC-1:0] pend;
  ctrlStrobeT         strobe;
  logic               thrIdentified;

  uirq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .lvlSrc       ({rxReady, rxTimeout, lineErr}),
    .txEmptyEvt   (txEmptyEvt),
    .edgeEvt      ({flowEvt, xoffEvt, gpioEvt, modemEvt}),
    .edgeClr      ({flowClr, xoffClr, gpioClr, modemClr}),
    .idRead       (idRead),
    .thrIdentified(thrIdentified),
    .pend         (pend),
    .strobe       (strobe)
  );

  uirq_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .fifoEn       (fifoEn),
    .pend         (pend),
    .srcEnable    (srcEnable),
    .strobe       (strobe),
    .idReg        (idReg),
    .thrIdentified(thrIdentified)
  );

  assign irqOut = ~idReg[0];
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0;
  logic [7:0] srcEnable = 8'hFF;
  logic       lineErr = 1'b0, rxTimeout = 1'b0, rxReady = 1'b0;
  logic [4:0] evt = '0;
  logic [3:0] clr = '0;
  logic       idRead = 1'b0;
  logic [7:0] idReg;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .srcEnable(srcEnable),
    .lineErr(lineErr), .rxTimeout(rxTimeout), .rxReady(rxReady),
    .txEmptyEvt(evt[0]), .modemEvt(evt[1]), .gpioEvt(evt[2]),
    .xoffEvt(evt[3]), .flowEvt(evt[4]),
    .modemClr(clr[0]), .gpioClr(clr[1]), .xoffClr(clr[2]), .flowClr(clr[3]),
    .idRead(idRead), .idReg(idReg), .irqOut(irqOut)
  );

  // Behavioural reference model
  bit [7:0] mId = 8'h01;
  bit [7:0] mLatch = '0;
  bit       mReadQ = 1'b0;
  bit       modelOn = 1'b0;

  function automatic bit [4:0] codeOf(int idx);
    case (idx)
      0: return 5'd3;  1: return 5'd6;  2: return 5'd2;  3: return 5'd1;
      4: return 5'd0;  5: return 5'd24; 6: return 5'd8;  default: return 5'd16;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mId = 8'h01; mLatch = '0; mReadQ = 1'b0; modelOn = 1'b1;
    end else begin
      bit [7:0] pendNow;
      bit [7:0] live;
      bit       hit;
      int       win;
      pendNow = {mLatch[7:3], rxReady, rxTimeout, lineErr} & srcEnable;
      win = -1;
      for (int i = 0; i < 8; i++) if (pendNow[i] && win < 0) win = i;
      live = (win < 0) ? 8'h01 : {2'b00, codeOf(win), 1'b0};
      live[7:6] = {fifoEn, fifoEn};
      hit = idRead && !mReadQ && (mId[5:0] == 6'b000010);
      if (!idRead) mId = live;
      mLatch[3] = evt[0] | (mLatch[3] & !hit);
      for (int k = 0; k < 4; k++) mLatch[4+k] = evt[1+k] | (mLatch[4+k] & !clr[k]);
      mReadQ = idRead;
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      checks++;
      if (idReg !== mId || irqOut !== ~mId[0]) begin
        failures++;
        $display("FAIL %s model: idReg=%h irq=%b expected idReg=%h irq=%b",
                 tag, idReg, irqOut, mId, ~mId[0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string t, input logic [7:0] exp);
    checks++;
    if (idReg !== exp || irqOut !== ~exp[0]) begin
      failures++;
      $display("FAIL %s: idReg=%h irq=%b expected idReg=%h irq=%b",
               t, idReg, irqOut, exp, ~exp[0]);
    end
  endtask

  task automatic pulseEvt(input int b);
    evt[b] = 1'b1; @(negedge clk); evt[b] = 1'b0;
  endtask

  task automatic pulseClr(input int b);
    clr[b] = 1'b1; @(negedge clk); clr[b] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h01);
    chk("R13 reset irq low", 8'h01);
    rstN = 1'b1;
    @(negedge clk); chk("R1 idle", 8'h01);

    tag = "R7";
    lineErr = 1; rxTimeout = 1; rxReady = 1;
    @(negedge clk); chk("R3 line error wins", 8'h06);
    lineErr = 0;
    @(negedge clk); chk("R4 timeout over rx ready", 8'h0C);
    rxTimeout = 0;
    @(negedge clk); chk("R4 rx ready code", 8'h04);
    rxReady = 0;
    @(negedge clk); chk("R10 level source gone", 8'h01);

    tag = "R2";
    fifoEn = 1;
    @(negedge clk); chk("R2 mirror set", 8'hC1);
    fifoEn = 0;
    @(negedge clk); chk("R2 mirror clear", 8'h01);

    tag = "R12";
    pulseEvt(0);
    @(negedge clk); chk("R5 thr code", 8'h02);
    idRead = 1;
    @(negedge clk); chk("R11 held during read", 8'h02);
    idRead = 0;
    @(negedge clk); chk("R12 thr cleared by read", 8'h01);
    @(negedge clk); chk("R12 thr stays clear", 8'h01);

    tag = "R6";
    pulseEvt(1);
    @(negedge clk); chk("R5 modem code", 8'h00);
    pulseEvt(2);
    @(negedge clk); chk("R7 modem over gpio", 8'h00);
    pulseClr(0);
    @(negedge clk); chk("R6 gpio code", 8'h30);
    pulseClr(1); pulseEvt(3);
    @(negedge clk); chk("R6 xoff code", 8'h10);
    pulseClr(2); pulseEvt(4);
    @(negedge clk); chk("R6 flow code", 8'h20);

    tag = "R8";
    srcEnable[7] = 0;
    @(negedge clk); chk("R8 masked source hidden", 8'h01);
    srcEnable[7] = 1;
    @(negedge clk); chk("R8 latch kept while masked", 8'h20);
    evt[4] = 1; clr[3] = 1; @(negedge clk); evt[4] = 0; clr[3] = 0;
    @(negedge clk); chk("R9 event beats clear", 8'h20);
    pulseClr(3);
    @(negedge clk); chk("R9 cleared by clear pulse", 8'h01);

    tag = "R12";
    lineErr = 1; pulseEvt(0);
    @(negedge clk); chk("R12 line error identified", 8'h06);
    idRead = 1; @(negedge clk); idRead = 0; lineErr = 0;
    @(negedge clk); chk("R12 thr survives other read", 8'h02);
    idRead = 1; @(negedge clk); idRead = 0;
    @(negedge clk); chk("R12 thr cleared after own read", 8'h01);

    tag = "R11";
    idRead = 1; lineErr = 1;
    @(negedge clk); @(negedge clk); chk("R11 frozen while reading", 8'h01);
    idRead = 0;
    @(negedge clk); chk("R11 updates after read", 8'h06);
    lineErr = 0;
    @(negedge clk);

    tag = "R7";
    for (int n = 0; n < 400; n++) begin
      lineErr   = ($urandom % 8) == 0;
      rxTimeout = ($urandom % 6) == 0;
      rxReady   = ($urandom % 4) == 0;
      evt       = 5'($urandom) & 5'($urandom);
      clr       = 4'($urandom);
      srcEnable = 8'($urandom) | 8'($urandom);
      fifoEn    = 1'($urandom);
      idRead    = ($urandom % 5) == 0;
      @(negedge clk);
    end
    evt = '0; clr = '0; idRead = 0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule